// File: doc/BRIEF.md
# Software-Maintained Translation Buffer with Staging Registers

This block is a sixteen-entry, fully associative translation buffer for 32-bit addresses. No hardware walker fills it. Software loads, reads and searches entries only through a small set of staging registers, and it issues single-cycle operation strobes: read entry, write entry, search, invalidate and synchronize. Each entry holds a valid bit, an invalidation-protect bit, an 8-bit process tag, an address-space bit, a 3-bit page size, a 20-bit virtual page number, a 20-bit physical page number and 6 permission bits.

There are six staging registers. The select register holds the table-select bit and the entry index. The entry-contents group has three words: tag/flags, virtual page and physical page with permissions. The miss-defaults register holds the table-select bit and the page size used on a miss. The search-context register holds the address space and the process tag used by a search. A separate miss-fill strobe loads the select and entry-contents registers from the miss defaults and the faulting address, so that software only has to finish the entry and write it.

The control sequencer has two named states. `ST_IDLE` waits for a strobe. `ST_ACK` drives the completion pulse. The transition `ST_IDLE -> ST_ACK` is taken when an operation strobe is present. `ST_ACK -> ST_ACK` is taken on a back-to-back strobe. `ST_ACK -> ST_IDLE` is taken when no strobe is present. `ST_IDLE -> ST_IDLE` is taken while nothing happens.

Top module: `tlbsw_mmu`

## Requirements
- R1: After reset, every entry is invalid, the victim pointer is 0, all six staging register outputs read 0 and `done` is 0.
- R2: Register write port: `reg_sel` 0=select, 1=tag/flags, 2=virtual page, 3=physical page, 4=miss defaults, 5=search context. Only these bits are kept: select [28]=table select, [3:0]=entry index. Tag/flags [31]=valid, [30]=protect, [23:16]=tag, [12]=address space, [10:8]=size. Virtual page [31:12]. Physical page [31:12]=page, [5:0]=permissions. Miss defaults [28]=table select, [10:8]=size. Search context [23:16]=tag, [0]=address space. All other bits read 0.
- R3: Write entry (`op_code` 1) with select[28]=1 copies the entry-contents fields into the indexed entry and advances the round-robin victim pointer by one, modulo 16. With select[28]=0 the entry and the pointer stay unchanged.
- R4: Read entry (`op_code` 0) with select[28]=1 copies the indexed entry into the entry-contents registers. With select[28]=0 those registers stay unchanged.
- R5: Search (`op_code` 2) compares `op_ea[31:12]` with each valid entry. An entry matches when its address space equals the search address space and its tag equals the search tag or is 0. On a hit, select becomes table select 1 with the matching index, and the entry-contents registers take the entry, including valid=1.
- R6: An entry of size code s ignores the lowest 2·s bits of the 20-bit page number in every compare (4 KB at s=0).
- R7: On a search miss, select becomes table select 1 with the victim pointer as index. Tag/flags becomes valid 0, protect 0, the search tag, the search address space and the default size. The virtual page becomes `op_ea[31:12]` and the physical page word becomes 0.
- R8: When several entries match a search, the lowest-numbered one is reported.
- R9: Invalidate (`op_code` 3) acts only when `op_ea[3]`=1. With `op_ea[2]`=0 it clears valid on every entry whose size-masked page number equals `op_ea[31:12]`, whatever its tag or address space, unless the entry's protect bit is 1. Bits [11:4] and [1:0] are ignored.
- R10: Invalidate with `op_ea[3]`=1 and `op_ea[2]`=1 clears valid on every entry whose protect bit is 0.
- R11: Synchronize (`op_code` 4) changes no staging register and no entry.
- R12: A `miss_fill` strobe sets select to the default table select and the victim index. Tag/flags becomes valid 1, protect 0, the search tag, `miss_as` and the default size. The virtual page becomes `miss_ea[31:12]`. The physical page word is unchanged.
- R13: Every operation takes effect at the clock edge that samples `op_valid`. `done` is 1 for the cycle after each operation strobe and 0 after any cycle without one. `miss_fill` does not raise `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Staging register write strobe |
| reg_sel | input | 3 | Staging register number |
| reg_wdata | input | 32 | Staging register write data |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 0 read, 1 write, 2 search, 3 invalidate, 4 synchronize |
| op_ea | input | 32 | Effective address for search and invalidate |
| miss_fill | input | 1 | Translation-miss notice, loads defaults |
| miss_ea | input | 32 | Faulting address for miss fill |
| miss_as | input | 1 | Faulting address space for miss fill |
| sel_q | output | 32 | Select register |
| ent_hi_q | output | 32 | Tag/flags register |
| ent_epn_q | output | 32 | Virtual page register |
| ent_rpn_q | output | 32 | Physical page and permissions register |
| miss_def_q | output | 32 | Miss-defaults register |
| srch_ctx_q | output | 32 | Search-context register |
| done | output | 1 | Completion pulse |

## Verification
A register write, operation or miss fill driven after one falling edge is captured at the next rising edge. Its effect on the staging registers is therefore visible at the falling edge after that, one clock after the stimulus. `done` is high in that same half-cycle window and must be low one cycle later. The driver pushes the expected values for exactly that falling edge and then hands them to the monitor, which compares them at that time. Entry contents are never read directly: each one is brought back through a read-entry operation or a search and checked one cycle later by the same rule.

// File: rtl/tlbsw_pkg.sv
package tlbsw_pkg;

    localparam int EPN_W  = 20;
    localparam int TID_W  = 8;
    localparam int SZ_W   = 3;
    localparam int PERM_W = 6;

    typedef struct packed {
        logic              valid;
        logic              prot;
        logic [TID_W-1:0]  tid;
        logic              ts;
        logic [SZ_W-1:0]   size;
        logic [EPN_W-1:0]  epn;
        logic [EPN_W-1:0]  rpn;
        logic [PERM_W-1:0] perm;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WRITE  = 3'd1,
        OP_SEARCH = 3'd2,
        OP_INVAL  = 3'd3,
        OP_SYNC   = 3'd4
    } tlb_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } tlb_state_e;

    // page-number bits that take part in a compare for a given size code
    function automatic logic [EPN_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
        return {EPN_W{1'b1}} << {sz, 1'b0};
    endfunction

endpackage

// File: rtl/tlbsw_match.sv
module tlbsw_match
    import tlbsw_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  tlb_entry_t [N_ENT-1:0] ents,
    input  logic [EPN_W-1:0]       va_epn,
    input  logic                   use_ctx,
    input  logic                   ctx_as,
    input  logic [TID_W-1:0]       ctx_pid,
    output logic [N_ENT-1:0]       hit_vec,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       hit_idx
);

    // one comparator per entry, all in parallel
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit_vec[i] = ents[i].valid
            && (((ents[i].epn ^ va_epn) & page_mask(ents[i].size)) == '0)
            && (!use_ctx || ((ents[i].ts == ctx_as)
                && ((ents[i].tid == ctx_pid) || (ents[i].tid == '0))));
    end

    assign any_hit = |hit_vec;

    // lowest index wins: scan downward so the last write is the lowest hit
    always_comb begin
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlbsw_store.sv
module tlbsw_store
    import tlbsw_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  tlb_entry_t             wr_data,
    input  logic [N_ENT-1:0]       clr_vec,
    output tlb_entry_t [N_ENT-1:0] ents
);

    tlb_entry_t ent_q [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ent_q[i] <= wr_data;
            end else if (clr_vec[i]) begin
                ent_q[i].valid <= 1'b0;
            end
        end

        assign ents[i] = ent_q[i];

        // the clear request computed by the controller never targets a protected entry
        p_prot_spared_r10 : assert property (@(posedge clk) disable iff (!rst_n)
            clr_vec[i] |-> !ent_q[i].prot);
    end

endmodule

// File: rtl/tlbsw_victim.sv
module tlbsw_victim #(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= ptr + 1'b1;
    end

    p_victim_step_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ptr == IDX_W'($past(ptr) + 1'b1)));

    p_victim_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));

endmodule

// File: rtl/tlbsw_mmu.sv
module tlbsw_mmu
    import tlbsw_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic [31:0] op_ea,
    input  logic        miss_fill,
    input  logic [31:0] miss_ea,
    input  logic        miss_as,
    output logic [31:0] sel_q,
    output logic [31:0] ent_hi_q,
    output logic [31:0] ent_epn_q,
    output logic [31:0] ent_rpn_q,
    output logic [31:0] miss_def_q,
    output logic [31:0] srch_ctx_q,
    output logic        done
);

    localparam int IDX_W = $clog2(N_ENT);

    // staging register fields
    logic              sel_tsel;
    logic [IDX_W-1:0]  sel_esel;
    logic              m1_v, m1_p, m1_ts;
    logic [TID_W-1:0]  m1_tid;
    logic [SZ_W-1:0]   m1_sz;
    logic [EPN_W-1:0]  m2_epn, m3_rpn;
    logic [PERM_W-1:0] m3_perm;
    logic              d_tsel;
    logic [SZ_W-1:0]   d_sz;
    logic [TID_W-1:0]  s_pid;
    logic              s_as;

    tlb_op_e    op;
    tlb_state_e st_q, st_d;

    logic [EPN_W-1:0]       op_epn;
    logic                   inv_tsel, inv_all;
    logic                   do_wr, do_inv;
    tlb_entry_t [N_ENT-1:0] ents;
    tlb_entry_t             wr_data, sel_ent, hit_ent;
    logic [N_ENT-1:0]       hit_vec, clr_vec;
    logic                   any_hit;
    logic [IDX_W-1:0]       hit_idx, victim;
    logic                   unused_bits;

    assign op       = tlb_op_e'(op_code);
    assign op_epn   = op_ea[31:12];
    assign inv_tsel = op_ea[3];
    assign inv_all  = op_ea[2];
    assign do_wr    = op_valid && (op == OP_WRITE) && sel_tsel;
    assign do_inv   = op_valid && (op == OP_INVAL) && inv_tsel;
    assign unused_bits = ^{reg_wdata[27:24], reg_wdata[15:13], reg_wdata[11], reg_wdata[7:6],
                           reg_wdata[29], reg_wdata[31:30], reg_wdata[3:1],
                           op_ea[11:4], op_ea[1:0], miss_ea[11:0]};

    assign wr_data = '{valid: m1_v, prot: m1_p, tid: m1_tid, ts: m1_ts, size: m1_sz,
                       epn: m2_epn, rpn: m3_rpn, perm: m3_perm};
    assign sel_ent = ents[sel_esel];
    assign hit_ent = ents[hit_idx];

    tlbsw_store #(.N_ENT(N_ENT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (do_wr),
        .wr_idx (sel_esel),
        .wr_data(wr_data),
        .clr_vec(clr_vec),
        .ents   (ents)
    );

    tlbsw_match #(.N_ENT(N_ENT)) u_match (
        .ents   (ents),
        .va_epn (op_epn),
        .use_ctx(op == OP_SEARCH),
        .ctx_as (s_as),
        .ctx_pid(s_pid),
        .hit_vec(hit_vec),
        .any_hit(any_hit),
        .hit_idx(hit_idx)
    );

    tlbsw_victim #(.N_ENT(N_ENT)) u_victim (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (do_wr),
        .ptr  (victim)
    );

    // invalidate: by address or all, never a protected entry
    for (genvar i = 0; i < N_ENT; i++) begin : g_clr
        assign clr_vec[i] = do_inv && !ents[i].prot && (inv_all || hit_vec[i]);
    end

    // sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // sequencer: transitions
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = op_valid ? ST_ACK : ST_IDLE;
            ST_ACK:  st_d = op_valid ? ST_ACK : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // sequencer: outputs
    always_comb begin
        unique case (st_q)
            ST_IDLE: done = 1'b0;
            ST_ACK:  done = 1'b1;
            default: done = 1'b0;
        endcase
    end

    // staging register update rules; operation > miss fill > software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_tsel <= 1'b0;  sel_esel <= '0;
            m1_v <= 1'b0;  m1_p <= 1'b0;  m1_ts <= 1'b0;  m1_tid <= '0;  m1_sz <= '0;
            m2_epn <= '0;  m3_rpn <= '0;  m3_perm <= '0;
            d_tsel <= 1'b0;  d_sz <= '0;  s_pid <= '0;  s_as <= 1'b0;
        end else if (op_valid) begin
            case (op)
                OP_READ: begin
                    if (sel_tsel) begin
                        m1_v <= sel_ent.valid;  m1_p <= sel_ent.prot;  m1_tid <= sel_ent.tid;
                        m1_ts <= sel_ent.ts;    m1_sz <= sel_ent.size;
                        m2_epn <= sel_ent.epn;  m3_rpn <= sel_ent.rpn; m3_perm <= sel_ent.perm;
                    end
                end
                OP_SEARCH: begin
                    sel_tsel <= 1'b1;
                    if (any_hit) begin
                        sel_esel <= hit_idx;
                        m1_v <= hit_ent.valid;  m1_p <= hit_ent.prot;  m1_tid <= hit_ent.tid;
                        m1_ts <= hit_ent.ts;    m1_sz <= hit_ent.size;
                        m2_epn <= hit_ent.epn;  m3_rpn <= hit_ent.rpn; m3_perm <= hit_ent.perm;
                    end else begin
                        sel_esel <= victim;
                        m1_v <= 1'b0;  m1_p <= 1'b0;  m1_tid <= s_pid;  m1_ts <= s_as;
                        m1_sz <= d_sz; m2_epn <= op_epn;  m3_rpn <= '0;  m3_perm <= '0;
                    end
                end
                default: ;
            endcase
        end else if (miss_fill) begin
            sel_tsel <= d_tsel;  sel_esel <= victim;
            m1_v <= 1'b1;  m1_p <= 1'b0;  m1_tid <= s_pid;  m1_ts <= miss_as;  m1_sz <= d_sz;
            m2_epn <= miss_ea[31:12];
        end else if (reg_we) begin
            case (reg_sel)
                3'd0: begin sel_tsel <= reg_wdata[28]; sel_esel <= reg_wdata[IDX_W-1:0]; end
                3'd1: begin
                    m1_v <= reg_wdata[31];  m1_p <= reg_wdata[30];  m1_tid <= reg_wdata[23:16];
                    m1_ts <= reg_wdata[12]; m1_sz <= reg_wdata[10:8];
                end
                3'd2: m2_epn <= reg_wdata[31:12];
                3'd3: begin m3_rpn <= reg_wdata[31:12]; m3_perm <= reg_wdata[5:0]; end
                3'd4: begin d_tsel <= reg_wdata[28]; d_sz <= reg_wdata[10:8]; end
                3'd5: begin s_pid <= reg_wdata[23:16]; s_as <= reg_wdata[0]; end
                default: ;
            endcase
        end
    end

    // register views
    always_comb begin
        sel_q = '0;
        sel_q[28] = sel_tsel;
        sel_q[IDX_W-1:0] = sel_esel;
        ent_hi_q = '0;
        ent_hi_q[31] = m1_v;
        ent_hi_q[30] = m1_p;
        ent_hi_q[23:16] = m1_tid;
        ent_hi_q[12] = m1_ts;
        ent_hi_q[10:8] = m1_sz;
        ent_epn_q = {m2_epn, 12'b0};
        ent_rpn_q = {m3_rpn, 6'b0, m3_perm};
        miss_def_q = '0;
        miss_def_q[28] = d_tsel;
        miss_def_q[10:8] = d_sz;
        srch_ctx_q = '0;
        srch_ctx_q[23:16] = s_pid;
        srch_ctx_q[0] = s_as;
    end

    // ---------------- assertions ----------------
    p_done_follows_op_r13 : assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> done);

    p_done_quiet_r13 : assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !done);

    p_sync_still_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_SYNC)) |=> ($stable(sel_q) && $stable(ent_hi_q)
            && $stable(ent_epn_q) && $stable(ent_rpn_q)
            && $stable(miss_def_q) && $stable(srch_ctx_q)));

    p_search_hit_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_SEARCH) && any_hit)
            |=> (ent_hi_q[31] && (sel_q[IDX_W-1:0] == $past(hit_idx))));

    p_search_miss_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op == OP_SEARCH) && !any_hit)
            |=> (!ent_hi_q[31] && (sel_q[IDX_W-1:0] == $past(victim))));

    p_lowest_hit_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_vec[hit_idx]
            && ((hit_vec & ((N_ENT'(1) << hit_idx) - N_ENT'(1))) == '0)));

    for (genvar i = 0; i < N_ENT; i++) begin : g_chk
        p_inv_prot_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            (do_inv && ents[i].prot && ents[i].valid && !(do_wr))
                |=> ents[i].valid);
    end

endmodule

// File: tb/tlbsw_mmu_tb.sv
module tlbsw_mmu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_ea = '0;
    logic        miss_fill = 1'b0;
    logic [31:0] miss_ea = '0;
    logic        miss_as = 1'b0;
    logic [31:0] sel_q, ent_hi_q, ent_epn_q, ent_rpn_q, miss_def_q, srch_ctx_q;
    logic        done;

    always #10 clk = ~clk;

    tlbsw_mmu u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .op_valid(op_valid), .op_code(op_code), .op_ea(op_ea),
        .miss_fill(miss_fill), .miss_ea(miss_ea), .miss_as(miss_as),
        .sel_q(sel_q), .ent_hi_q(ent_hi_q), .ent_epn_q(ent_epn_q), .ent_rpn_q(ent_rpn_q),
        .miss_def_q(miss_def_q), .srch_ctx_q(srch_ctx_q), .done(done)
    );

    typedef struct {
        int          which;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    int   v_ptr = 0;
    bit   finished = 1'b0;

    function automatic logic [31:0] port_val(input int w);
        case (w)
            0: return sel_q;
            1: return ent_hi_q;
            2: return ent_epn_q;
            3: return ent_rpn_q;
            4: return miss_def_q;
            5: return srch_ctx_q;
            default: return {31'b0, done};
        endcase
    endfunction

    function automatic logic [31:0] mk1(input logic v, input logic p, input logic [7:0] tid,
                                         input logic ts, input logic [2:0] sz);
        return {v, p, 6'b0, tid, 3'b0, ts, 1'b0, sz, 8'b0};
    endfunction

    // monitor: pops expected items and compares them with the ports
    always begin
        @(chk_ev);
        while (exp_q.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = port_val(it.which);
            n_chk++;
            if (act !== it.val) begin
                n_fail++;
                $display("FAIL %s: port %0d actual %h expected %h", it.req, it.which, act, it.val);
            end
        end
    end

    task automatic push(input int w, input logic [31:0] v, input string rq);
        exp_t it;
        it.which = w; it.val = v; it.req = rq;
        exp_q.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic set_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic do_op(input logic [2:0] c, input logic [31:0] ea);
        @(negedge clk); op_valid = 1'b1; op_code = c; op_ea = ea;
        @(negedge clk); op_valid = 1'b0;
        push(6, 32'd1, "R13");
    endtask

    task automatic write_entry(input int idx, input logic [31:0] hi, input logic [19:0] epn,
                               input logic [19:0] rpn, input logic [5:0] perm);
        set_reg(3'd0, 32'h1000_0000 | idx);
        set_reg(3'd1, hi);
        set_reg(3'd2, {epn, 12'b0});
        set_reg(3'd3, {rpn, 6'b0, perm});
        do_op(3'd1, 32'h0);
        flush();
        v_ptr = (v_ptr + 1) % 16;
    endtask

    task automatic search(input logic [31:0] ea, input logic [7:0] pid, input logic as_b);
        set_reg(3'd5, {8'b0, pid, 15'b0, as_b});
        do_op(3'd2, ea);
    endtask

    task automatic expect_ent(input logic [31:0] s, input logic [31:0] h, input logic [31:0] e,
                              input logic [31:0] r, input string rq);
        push(0, s, rq); push(1, h, rq); push(2, e, rq); push(3, r, rq);
        flush();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap [6];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int w = 0; w < 7; w++) push(w, 32'h0, "R1");
        flush();

        // R2: field masks on write
        set_reg(3'd4, 32'hFFFF_FFFF); push(4, 32'h1000_0700, "R2"); flush();
        set_reg(3'd1, 32'hFFFF_FFFF); push(1, 32'hC0FF_1700, "R2"); flush();
        set_reg(3'd3, 32'hFFFF_FFFF); push(3, 32'hFFFF_F03F, "R2"); flush();
        set_reg(3'd0, 32'hFFFF_FFFF); push(0, 32'h1000_000F, "R2"); flush();
        set_reg(3'd5, 32'hFFFF_FFFF); push(5, 32'h00FF_0001, "R2"); flush();
        set_reg(3'd4, 32'h1000_0100);

        // R3: populate four entries
        write_entry(0, mk1(1, 0, 8'd5, 0, 3'd0), 20'h12345, 20'hABCDE, 6'h15);
        write_entry(1, mk1(1, 1, 8'd0, 0, 3'd2), 20'h40000, 20'h11111, 6'h03);
        write_entry(2, mk1(1, 0, 8'd7, 1, 3'd0), 20'h12345, 20'h22222, 6'h01);
        write_entry(3, mk1(1, 0, 8'd0, 0, 3'd0), 20'h12345, 20'h33333, 6'h00);

        // R5 R8: two matches, lowest reported
        search(32'h1234_5678, 8'd5, 1'b0);
        expect_ent(32'h1000_0000, 32'h8005_0000, 32'h1234_5000, 32'hABCD_E015, "R8");
        // R5: global tag 0 matches any search tag
        search(32'h1234_5000, 8'd9, 1'b0);
        expect_ent(32'h1000_0003, 32'h8000_0000, 32'h1234_5000, 32'h3333_3000, "R5");
        // R5: address space selects entry 2
        search(32'h1234_5ABC, 8'd7, 1'b1);
        expect_ent(32'h1000_0002, 32'h8007_1000, 32'h1234_5000, 32'h2222_2001, "R5");
        // R6: size code 2 ignores four low page bits
        search(32'h4000_F000, 8'd9, 1'b0);
        expect_ent(32'h1000_0001, 32'hC000_0200, 32'h4000_0000, 32'h1111_1003, "R6");
        // R6 R7: just outside the page, miss with defaults
        search(32'h4001_0000, 8'd9, 1'b0);
        expect_ent(32'h1000_0000 | v_ptr, 32'h0009_0100, 32'h4001_0000, 32'h0, "R7");

        // R4: read entry 2
        set_reg(3'd0, 32'h1000_0002);
        do_op(3'd0, 32'h0);
        expect_ent(32'h1000_0002, 32'h8007_1000, 32'h1234_5000, 32'h2222_2001, "R4");
        // R4: read with table select 0 leaves registers
        set_reg(3'd0, 32'h0000_0000);
        do_op(3'd0, 32'h0);
        expect_ent(32'h0000_0000, 32'h8007_1000, 32'h1234_5000, 32'h2222_2001, "R4");

        // R3: write with table select 0 is ignored
        set_reg(3'd0, 32'h0000_0005);
        set_reg(3'd1, mk1(1, 0, 8'd0, 0, 3'd0));
        set_reg(3'd2, 32'h5555_5000);
        do_op(3'd1, 32'h0); flush();
        set_reg(3'd0, 32'h1000_0005);
        do_op(3'd0, 32'h0);
        expect_ent(32'h1000_0005, 32'h0, 32'h0, 32'h0, "R3");
        search(32'h9999_9000, 8'd0, 1'b0);
        push(0, 32'h1000_0000 | v_ptr, "R3"); flush();

        // R13: done drops the cycle after
        @(negedge clk); push(6, 32'd0, "R13"); flush();

        // R11: synchronize keeps everything
        for (int w = 0; w < 6; w++) snap[w] = port_val(w);
        do_op(3'd4, 32'hFFFF_FFFF);
        for (int w = 0; w < 6; w++) push(w, snap[w], "R11");
        flush();

        // protected entry 4
        write_entry(4, mk1(1, 1, 8'd0, 0, 3'd0), 20'h77777, 20'h44444, 6'h00);

        // R9: table select 0 means no invalidate
        do_op(3'd3, 32'h1234_5FF3); flush();
        search(32'h1234_5000, 8'd5, 1'b0);
        push(0, 32'h1000_0000, "R9"); push(1, 32'h8005_0000, "R9"); flush();
        // R9: by address, reserved bits set, tag and space ignored
        do_op(3'd3, 32'h1234_5FFB); flush();
        search(32'h1234_5000, 8'd5, 1'b0);
        expect_ent(32'h1000_0000 | v_ptr, 32'h0005_0100, 32'h1234_5000, 32'h0, "R9");
        set_reg(3'd0, 32'h1000_0002);
        do_op(3'd0, 32'h0);
        push(1, 32'h0007_1000, "R9"); flush();
        // R9: protected entry survives address invalidate
        do_op(3'd3, 32'h7777_7008); flush();
        search(32'h7777_7000, 8'd3, 1'b0);
        expect_ent(32'h1000_0004, 32'hC000_0000, 32'h7777_7000, 32'h4444_4000, "R9");

        // R10: invalidate all spares protected entries
        write_entry(0, mk1(1, 0, 8'd5, 0, 3'd0), 20'h12345, 20'hABCDE, 6'h15);
        do_op(3'd3, 32'h0000_000C); flush();
        search(32'h1234_5000, 8'd5, 1'b0);
        push(0, 32'h1000_0000 | v_ptr, "R10"); push(1, 32'h0005_0100, "R10"); flush();
        search(32'h4000_F000, 8'd9, 1'b0);
        push(0, 32'h1000_0001, "R10"); push(1, 32'hC000_0200, "R10"); flush();
        search(32'h7777_7000, 8'd3, 1'b0);
        push(0, 32'h1000_0004, "R10"); push(1, 32'hC000_0000, "R10"); flush();

        // R12: miss fill, physical page word unchanged, no done
        set_reg(3'd5, 32'h002A_0000);
        @(negedge clk); miss_fill = 1'b1; miss_ea = 32'hDEAD_B123; miss_as = 1'b1;
        @(negedge clk); miss_fill = 1'b0;
        expect_ent(32'h1000_0000 | v_ptr, mk1(1, 0, 8'h2A, 1, 3'd1), 32'hDEAD_B000,
                   32'h4444_4000, "R12");
        push(6, 32'd0, "R13"); flush();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule